// File: doc/BRIEF.md
# Single-Cycle Register Update Bypass

This block is the register write-back stage of a small 8-bit accumulator processor. It holds the four architectural registers: accumulator, X index, Y index and stack pointer. It also holds the six status flags. Implied-mode instructions that touch neither memory nor the stack are completed without a trip through the main ALU. Such an instruction is decoded in one DECODE cycle. In the very next cycle, a private step unit reads the chosen register, adds minus one, zero or plus one, and writes the result back. That cycle is normally the DECODE cycle of the following instruction, so one of these instructions can be issued on every clock.

A registered fast flag remembers that the decoded operation belongs to this short path. The flag steers the write-back mux to the step unit instead of the ALU result. Slow operations still go through a REG cycle and write the externally computed ALU value afterwards. A subroutine-call save cycle overrides both sources and writes the data-input value. Flags are updated on both the fast path and the ALU path.

Top module: `regwb_bypass`

## Requirements
- R1: After reset, A, X and Y are 0x00, S is 0xFF, `fast_o` is 0, and `flags_o` is 0x04. The flag bits are: bit0 carry, bit1 zero, bit2 interrupt-disable, bit3 decimal, bit4 overflow, bit5 negative.
- R2: The `op_i` codes are 0 no-op, 1 increment, 2 decrement, 3 transfer, 4 flag set, 5 flag clear, 6 ALU write, 7 reserved. When `dec_en_i` is high at an edge, `fast_o` goes to 1 after that edge for codes 1 to 5 and to 0 for codes 0, 6 and 7. Codes 0 and 7 never change a register or a flag.
- R3: An operation with code 1 to 5, decoded at edge k, has its effect visible after edge k+1 when the state at k+1 is DECODE (0) or OTHER (3). Such operations can be decoded on every clock, and each one sees the result of the operation before it.
- R4: Increment and decrement act on the register chosen by `dst_sel_i` and wrap modulo 256: 0xFF+1 gives 0x00 and 0x00-1 gives 0xFF.
- R5: A transfer copies the register chosen by `src_sel_i` into the register chosen by `dst_sel_i` and leaves the source register unchanged.
- R6: An ALU write (code 6) changes nothing while the state is REG (1). At the first later edge whose state is DECODE or OTHER, it writes `alu_res_i` into the destination register and sets zero and negative from that value.
- R7: Increment, decrement and transfers into A, X or Y set the zero flag exactly when the 8-bit result is 0x00, and set the negative flag equal to result bit 7.
- R8: A transfer into S leaves all six flags unchanged.
- R9: Flag set and clear write no register. They change only the flag named by `flag_sel_i` (0 carry, 1 interrupt-disable, 2 decimal, 3 overflow).
- R10: In the call-save state (2), `din_i` is written into the register chosen by `dst_sel_i` at that edge, and the flags do not change. Any pending write-back is discarded.
- R11: Register select codes are 0 A, 1 X, 2 Y, 3 S, for both source and destination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| state_i | input | 2 | Sequencer state: 0 DECODE, 1 REG, 2 call-save, 3 other |
| dec_en_i | input | 1 | A new operation is decoded at this edge |
| op_i | input | 3 | Operation code of the decoded instruction |
| src_sel_i | input | 2 | Source register select for transfers |
| dst_sel_i | input | 2 | Destination register select |
| flag_sel_i | input | 2 | Flag targeted by set/clear |
| alu_res_i | input | 8 | Result from the main ALU |
| din_i | input | 8 | Data-input mux value for the call-save write |
| reg_a_o | output | 8 | Accumulator |
| reg_x_o | output | 8 | X index |
| reg_y_o | output | 8 | Y index |
| reg_s_o | output | 8 | Stack pointer |
| flags_o | output | 6 | Status flags (layout in R1) |
| fast_o | output | 1 | Registered fast-path flag |

## Verification
The bench issues dependent increments on consecutive clocks. A design that read the register before the previous write landed, or that needed a REG cycle, would produce stale or late values. It drives the wrap points 0xFF+1 and 0x00-1 and checks zero and negative on each. It also moves a negative value into S, where a design that updated flags there would corrupt zero and negative. Finally, it places a call-save cycle right after a pending ALU write: the wrong priority would leave the ALU value in the register, and a write that was not dropped would land one cycle late.

// File: rtl/regwb_pkg.sv
package regwb_pkg;

  typedef enum logic [1:0] {
    ST_DECODE   = 2'd0,
    ST_REG      = 2'd1,
    ST_CALLSAVE = 2'd2,
    ST_OTHER    = 2'd3
  } state_e;

  typedef enum logic [2:0] {
    OP_NOP  = 3'd0,
    OP_INC  = 3'd1,
    OP_DEC  = 3'd2,
    OP_XFER = 3'd3,
    OP_FSET = 3'd4,
    OP_FCLR = 3'd5,
    OP_ALU  = 3'd6,
    OP_RSVD = 3'd7
  } op_e;

  typedef enum logic [1:0] {
    STEP_ZERO = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DOWN = 2'd2
  } step_e;

  localparam int SEL_W = 2;
  localparam int NREG  = 4;
  localparam logic [SEL_W-1:0] RS_A = 2'd0;
  localparam logic [SEL_W-1:0] RS_X = 2'd1;
  localparam logic [SEL_W-1:0] RS_Y = 2'd2;
  localparam logic [SEL_W-1:0] RS_S = 2'd3;

  localparam int FL_C = 0;
  localparam int FL_Z = 1;
  localparam int FL_I = 2;
  localparam int FL_D = 3;
  localparam int FL_V = 4;
  localparam int FL_N = 5;
  localparam int FL_W = 6;

  typedef struct packed {
    logic             pend;
    logic             fast;
    logic             wr_reg;
    logic             upd_zn;
    logic             flag_op;
    logic             flag_val;
    logic [1:0]       flag_sel;
    logic [SEL_W-1:0] src;
    logic [SEL_W-1:0] dst;
    step_e            step;
  } wb_ctrl_t;

  function automatic int flag_pos(input logic [1:0] sel);
    case (sel)
      2'd0:    return FL_C;
      2'd1:    return FL_I;
      2'd2:    return FL_D;
      default: return FL_V;
    endcase
  endfunction

endpackage

// File: rtl/regwb_decode.sv
module regwb_decode
  import regwb_pkg::*;
(
  input  logic [2:0]       op_i,
  input  logic [SEL_W-1:0] src_i,
  input  logic [SEL_W-1:0] dst_i,
  input  logic [1:0]       fsel_i,
  output wb_ctrl_t         ctrl_o
);

  always_comb begin
    ctrl_o          = '0;
    ctrl_o.src      = src_i;
    ctrl_o.dst      = dst_i;
    ctrl_o.flag_sel = fsel_i;
    ctrl_o.step     = STEP_ZERO;
    case (op_e'(op_i))
      OP_INC, OP_DEC: begin
        ctrl_o.pend   = 1'b1;
        ctrl_o.fast   = 1'b1;
        ctrl_o.wr_reg = 1'b1;
        ctrl_o.upd_zn = 1'b1;
        ctrl_o.src    = dst_i;
        ctrl_o.step   = (op_e'(op_i) == OP_INC) ? STEP_UP : STEP_DOWN;
      end
      OP_XFER: begin
        ctrl_o.pend   = 1'b1;
        ctrl_o.fast   = 1'b1;
        ctrl_o.wr_reg = 1'b1;
        ctrl_o.upd_zn = (dst_i != RS_S);
      end
      OP_FSET, OP_FCLR: begin
        ctrl_o.pend     = 1'b1;
        ctrl_o.fast     = 1'b1;
        ctrl_o.flag_op  = 1'b1;
        ctrl_o.flag_val = (op_e'(op_i) == OP_FSET);
      end
      OP_ALU: begin
        ctrl_o.pend   = 1'b1;
        ctrl_o.wr_reg = 1'b1;
        ctrl_o.upd_zn = 1'b1;
      end
      default: ctrl_o = '0;
    endcase
  end

endmodule

// File: rtl/regwb_step.sv
module regwb_step
  import regwb_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] val_i,
  input  step_e             step_i,
  output logic [DATA_W-1:0] res_o
);

  function automatic logic [DATA_W-1:0] apply_step(input logic [DATA_W-1:0] v, input step_e s);
    case (s)
      STEP_UP:   return v + DATA_W'(1);
      STEP_DOWN: return v - DATA_W'(1);
      default:   return v;
    endcase
  endfunction

  assign res_o = apply_step(val_i, step_i);

endmodule

// File: rtl/regwb_bypass.sv
module regwb_bypass
  import regwb_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        state_i,
  input  logic              dec_en_i,
  input  logic [2:0]        op_i,
  input  logic [1:0]        src_sel_i,
  input  logic [1:0]        dst_sel_i,
  input  logic [1:0]        flag_sel_i,
  input  logic [DATA_W-1:0] alu_res_i,
  input  logic [DATA_W-1:0] din_i,
  output logic [DATA_W-1:0] reg_a_o,
  output logic [DATA_W-1:0] reg_x_o,
  output logic [DATA_W-1:0] reg_y_o,
  output logic [DATA_W-1:0] reg_s_o,
  output logic [FL_W-1:0]   flags_o,
  output logic              fast_o
);

  localparam int FLAT_W = NREG * DATA_W;

  state_e             st;
  wb_ctrl_t           dec_c;
  wb_ctrl_t           pend_q;
  logic [DATA_W-1:0]  rf_q [NREG];
  logic [FLAT_W-1:0]  rf_flat;
  logic [FL_W-1:0]    fl_q;

  // named internal events
  logic               call_save;
  logic               wb_fire;
  logic               wb_we;
  logic [SEL_W-1:0]   wb_dst;
  logic [DATA_W-1:0]  step_in;
  logic [DATA_W-1:0]  step_out;
  logic [DATA_W-1:0]  wb_val;

  assign st = state_e'(state_i);

  regwb_decode u_dec (
    .op_i   (op_i),
    .src_i  (src_sel_i),
    .dst_i  (dst_sel_i),
    .fsel_i (flag_sel_i),
    .ctrl_o (dec_c)
  );

  assign step_in = rf_q[pend_q.src];

  regwb_step #(.DATA_W(DATA_W)) u_step (
    .val_i  (step_in),
    .step_i (pend_q.step),
    .res_o  (step_out)
  );

  assign call_save = (st == ST_CALLSAVE);
  assign wb_fire   = pend_q.pend && (st != ST_REG) && !call_save;
  // priority: call-save data, then step unit, then ALU
  assign wb_val    = call_save   ? din_i    :
                     pend_q.fast ? step_out : alu_res_i;
  assign wb_dst    = call_save ? dst_sel_i : pend_q.dst;
  assign wb_we     = call_save || (wb_fire && pend_q.wr_reg);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              pend_q <= '0;
    else if (dec_en_i)       pend_q <= dec_c;
    else if (st != ST_REG)   pend_q <= '0;
  end

  for (genvar g = 0; g < NREG; g++) begin : g_rf
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                rf_q[g] <= (g == int'(RS_S)) ? '1 : '0;
      else if (wb_we && (wb_dst == SEL_W'(g)))   rf_q[g] <= wb_val;
    end
    assign rf_flat[g*DATA_W +: DATA_W] = rf_q[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fl_q       <= '0;
      fl_q[FL_I] <= 1'b1;
    end else if (wb_fire) begin
      if (pend_q.upd_zn) begin
        fl_q[FL_Z] <= (wb_val == '0);
        fl_q[FL_N] <= wb_val[DATA_W-1];
      end
      if (pend_q.flag_op) fl_q[flag_pos(pend_q.flag_sel)] <= pend_q.flag_val;
    end
  end

  assign reg_a_o = rf_q[RS_A];
  assign reg_x_o = rf_q[RS_X];
  assign reg_y_o = rf_q[RS_Y];
  assign reg_s_o = rf_q[RS_S];
  assign flags_o = fl_q;
  assign fast_o  = pend_q.fast;

  // ---------------- assertions ----------------
  assert_fast_no_reg_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q.fast |-> (st != ST_REG));

  assert_inc_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_fire && pend_q.fast && pend_q.step == STEP_UP) |=>
      rf_q[$past(pend_q.dst)] == $past(step_in) + DATA_W'(1));

  assert_dec_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_fire && pend_q.fast && pend_q.step == STEP_DOWN) |=>
      rf_q[$past(pend_q.dst)] == $past(step_in) - DATA_W'(1));

  assert_xfer_copy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_fire && pend_q.fast && pend_q.wr_reg && pend_q.step == STEP_ZERO) |=>
      rf_q[$past(pend_q.dst)] == $past(rf_q[pend_q.src]));

  assert_reg_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_REG) |=> $stable(rf_flat));

  assert_zn_track_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_fire && pend_q.upd_zn) |=>
      (fl_q[FL_Z] == ($past(wb_val) == '0)) && (fl_q[FL_N] == $past(wb_val[DATA_W-1])));

  assert_s_xfer_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_fire && pend_q.wr_reg && !pend_q.upd_zn) |=> $stable(fl_q));

  assert_flag_op_regs_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_fire && pend_q.flag_op) |=>
      $stable(rf_flat) && $stable(fl_q[FL_Z]) && $stable(fl_q[FL_N]));

  assert_callsave_R10: assert property (@(posedge clk) disable iff (!rst_n)
    call_save |=> (rf_q[$past(dst_sel_i)] == $past(din_i)) && $stable(fl_q));

endmodule

// File: tb/regwb_bypass_bench.sv
module regwb_bypass_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] state_i;
  logic       dec_en_i;
  logic [2:0] op_i;
  logic [1:0] src_sel_i, dst_sel_i, flag_sel_i;
  logic [7:0] alu_res_i, din_i;
  logic [7:0] reg_a_o, reg_x_o, reg_y_o, reg_s_o;
  logic [5:0] flags_o;
  logic       fast_o;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // reference model
  logic [7:0] m_reg [4];
  logic [5:0] m_fl;
  logic       m_fast;
  logic [2:0] p_op;
  logic [1:0] p_src, p_dst, p_fs;

  always #4 clk = ~clk;

  regwb_bypass u_regwb_bypass (
    .clk(clk), .rst_n(rst_n), .state_i(state_i), .dec_en_i(dec_en_i), .op_i(op_i),
    .src_sel_i(src_sel_i), .dst_sel_i(dst_sel_i), .flag_sel_i(flag_sel_i),
    .alu_res_i(alu_res_i), .din_i(din_i),
    .reg_a_o(reg_a_o), .reg_x_o(reg_x_o), .reg_y_o(reg_y_o), .reg_s_o(reg_s_o),
    .flags_o(flags_o), .fast_o(fast_o)
  );

  function automatic int bit_of_flag(input logic [1:0] fs);
    // carry 0, interrupt-disable 2, decimal 3, overflow 4
    if (fs == 2'd0) return 0;
    return int'(fs) + 1;
  endfunction

  task automatic set_zn(input logic [7:0] v);
    m_fl[1] = (v == 8'h00);
    m_fl[5] = v[7];
  endtask

  task automatic chk(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    chk(tag, "A", reg_a_o, m_reg[0]);
    chk(tag, "X", reg_x_o, m_reg[1]);
    chk(tag, "Y", reg_y_o, m_reg[2]);
    chk(tag, "S", reg_s_o, m_reg[3]);
    chk(tag, "flags", {2'b00, flags_o}, {2'b00, m_fl});
    chk(tag, "fast", {7'd0, fast_o}, {7'd0, m_fast});
  endtask

  task automatic cyc(input logic [1:0] st, input logic en, input logic [2:0] op,
                     input logic [1:0] src, input logic [1:0] dst, input logic [1:0] fs,
                     input logic [7:0] alu, input logic [7:0] din, input string tag);
    logic [7:0] v;
    @(negedge clk);
    state_i = st; dec_en_i = en; op_i = op; src_sel_i = src; dst_sel_i = dst;
    flag_sel_i = fs; alu_res_i = alu; din_i = din;
    @(posedge clk);
    if (st == 2'd2) begin
      m_reg[dst] = din;
      p_op = 3'd0;
    end else if (st != 2'd1) begin
      case (p_op)
        3'd1: begin v = m_reg[p_dst] + 8'd1; m_reg[p_dst] = v; set_zn(v); end
        3'd2: begin v = m_reg[p_dst] - 8'd1; m_reg[p_dst] = v; set_zn(v); end
        3'd3: begin v = m_reg[p_src]; m_reg[p_dst] = v; if (p_dst != 2'd3) set_zn(v); end
        3'd4: m_fl[bit_of_flag(p_fs)] = 1'b1;
        3'd5: m_fl[bit_of_flag(p_fs)] = 1'b0;
        3'd6: begin m_reg[p_dst] = alu; set_zn(alu); end
        default: ;
      endcase
    end
    if (en) begin
      p_op = op; p_src = src; p_dst = dst; p_fs = fs;
    end else if (st != 2'd1) begin
      p_op = 3'd0;
    end
    m_fast = (p_op >= 3'd1) && (p_op <= 3'd5);
    #1;
    check_all(tag);
  endtask

  // decode in DECODE state
  task automatic dop(input logic [2:0] op, input logic [1:0] src, input logic [1:0] dst,
                     input logic [1:0] fs, input string tag);
    cyc(2'd0, 1'b1, op, src, dst, fs, 8'h00, 8'h00, tag);
  endtask

  task automatic idle(input string tag);
    cyc(2'd0, 1'b0, 3'd0, 2'd0, 2'd0, 2'd0, 8'h00, 8'h00, tag);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'd20240611);
    rst_n = 1'b0; state_i = 0; dec_en_i = 0; op_i = 0; src_sel_i = 0; dst_sel_i = 0;
    flag_sel_i = 0; alu_res_i = 0; din_i = 0;
    m_reg[0] = 8'h00; m_reg[1] = 8'h00; m_reg[2] = 8'h00; m_reg[3] = 8'hFF;
    m_fl = 6'b000100; m_fast = 1'b0; p_op = 0; p_src = 0; p_dst = 0; p_fs = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check_all("R1 reset");

    // R3/R4: one-cycle increment of X, then decrements through zero
    dop(3'd1, 2'd0, 2'd1, 2'd0, "R3 inc X decode");
    dop(3'd2, 2'd0, 2'd1, 2'd0, "R4 dec X");
    dop(3'd2, 2'd0, 2'd1, 2'd0, "R4 dec X to zero");
    idle("R4 R7 wrap 00-1 gives FF negative");

    // R10/R11: load Y with FF, then increment wraps to 00 with zero set
    cyc(2'd2, 1'b0, 3'd0, 2'd0, 2'd2, 2'd0, 8'h00, 8'hFF, "R10 R11 callsave Y");
    dop(3'd1, 2'd0, 2'd2, 2'd0, "R4 inc Y");
    idle("R4 R7 wrap FF+1 gives 00 zero");

    // R3: back-to-back dependent increments every clock
    for (int i = 0; i < 4; i++) dop(3'd1, 2'd0, 2'd1, 2'd0, "R3 back-to-back inc X");
    idle("R3 last inc lands");

    // R5: transfer X->A, source unchanged
    dop(3'd3, 2'd1, 2'd0, 2'd0, "R5 xfer X to A");
    idle("R5 R7 xfer result");

    // R8: negative value into S leaves flags
    cyc(2'd2, 1'b0, 3'd0, 2'd0, 2'd1, 2'd0, 8'h00, 8'h80, "R10 callsave X 80");
    dop(3'd1, 2'd0, 2'd2, 2'd0, "R7 inc Y to 01");
    dop(3'd3, 2'd1, 2'd3, 2'd0, "R8 xfer X to S");
    idle("R8 flags unchanged after S xfer");
    dop(3'd3, 2'd3, 2'd0, 2'd0, "R5 R11 xfer S to A");
    idle("R7 negative from A");

    // R9: set then clear each selectable flag
    for (int f = 0; f < 4; f++) dop(3'd4, 2'd0, 2'd0, 2'(f), "R9 flag set");
    for (int f = 0; f < 4; f++) dop(3'd5, 2'd0, 2'd0, 2'(f), "R9 flag clear");
    idle("R9 last flag op");

    // R2: codes 0 and 7 do nothing and are not fast
    dop(3'd0, 2'd1, 2'd0, 2'd0, "R2 nop code");
    dop(3'd7, 2'd1, 2'd0, 2'd0, "R2 reserved code");
    idle("R2 no effect");

    // R6: ALU write through REG cycle
    dop(3'd6, 2'd0, 2'd0, 2'd0, "R6 alu decode");
    cyc(2'd1, 1'b0, 3'd0, 2'd0, 2'd0, 2'd0, 8'h55, 8'h00, "R6 REG no write");
    cyc(2'd0, 1'b0, 3'd0, 2'd0, 2'd0, 2'd0, 8'h00, 8'h00, "R6 alu write zero");
    dop(3'd6, 2'd0, 2'd2, 2'd0, "R6 alu decode Y");
    cyc(2'd1, 1'b0, 3'd0, 2'd0, 2'd0, 2'd0, 8'h11, 8'h00, "R6 REG hold");
    cyc(2'd3, 1'b0, 3'd0, 2'd0, 2'd0, 2'd0, 8'hC3, 8'h00, "R6 alu write in other state");

    // R10: call-save overrides pending ALU write, which is dropped
    dop(3'd6, 2'd0, 2'd0, 2'd0, "R10 alu decode");
    cyc(2'd1, 1'b0, 3'd0, 2'd0, 2'd0, 2'd0, 8'h99, 8'h00, "R10 REG");
    cyc(2'd2, 1'b0, 3'd0, 2'd0, 2'd0, 2'd0, 8'h99, 8'h3C, "R10 callsave wins");
    cyc(2'd0, 1'b0, 3'd0, 2'd0, 2'd0, 2'd0, 8'h99, 8'h00, "R10 dropped write");

    // random mix
    for (int n = 0; n < 600; n++) begin
      int r;
      logic [2:0] op;
      r  = int'($urandom_range(0, 9));
      op = 3'($urandom_range(0, 7));
      if (r == 0) begin
        cyc(2'd2, 1'b0, 3'd0, 2'd0, 2'($urandom_range(0, 3)), 2'd0, 8'h00,
            8'($urandom_range(0, 255)), "R10 random callsave");
      end else if (r == 1) begin
        cyc(2'd3, 1'b0, 3'd0, 2'd0, 2'd0, 2'd0, 8'($urandom_range(0, 255)), 8'h00, "R3 random other");
      end else begin
        cyc(2'd0, 1'b1, op, 2'($urandom_range(0, 3)), 2'($urandom_range(0, 3)),
            2'($urandom_range(0, 3)), 8'h00, 8'h00, "R3 R7 random op");
        if (op == 3'd6)
          cyc(2'd1, 1'b0, 3'd0, 2'd0, 2'd0, 2'd0, 8'($urandom_range(0, 255)), 8'h00, "R6 random REG");
      end
    end
    cyc(2'd0, 1'b0, 3'd0, 2'd0, 2'd0, 2'd0, 8'h7E, 8'h00, "R6 random drain");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule